// File: doc/BRIEF.md
# Microsequenced Floating-Point Add Unit

This unit carries out a floating-point add of two words held in a small word-addressed operand store. It does not use one wide combinational adder. A control sequencer steps through fixed micro-operations, one state per step:

- four single-field loads;
- a three-way exponent compare;
- alignment of the smaller operand;
- a mantissa add;
- a normalise loop;
- a write of the sum back over the first operand.

Each operand word is 24 bits. Bits 23:16 hold an unsigned biased exponent. Bits 15:0 hold an unsigned mantissa. A normalised nonzero mantissa has bit 15 set, and a zero mantissa stands for the value zero.

A caller pulses `start` with two store addresses, `src_a` and `src_b`. It then waits for the one-cycle `done` pulse, which coincides with the write of the sum to address `src_a`. The store is outside the block and is reached through one port with a combinational read and a clocked write. The `ovf` and `udf` flags report a result exponent that left the range 0 to 255. They stay set until the next accepted start.

Top module: `fpaddms_top`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we`, `ovf` and `udf` are all 0.
- R2: In the four cycles after an accepted start, `mem_addr` is src_a, src_a, src_b, src_b. These cycles load, in order, the exponent (bits 23:16) of A, the mantissa (bits 15:0) of A, the exponent of B and the mantissa of B.
- R3: When both exponents are equal, the mantissas are added without shifting and the result exponent starts from that shared exponent.
- R4: When the exponent of A is smaller, the mantissa of A is shifted right by the exponent difference and then added to the mantissa of B. The result exponent starts from the exponent of B.
- R5: When the exponent of B is smaller, the mantissa of B is shifted right by the exponent difference and then added to the mantissa of A. The result exponent starts from the exponent of A.
- R6: An exponent difference of 16 or more turns the shifted mantissa into zero.
- R7: The add is 17 bits wide. When bit 16 of the sum is set and the exponent is below 255, the sum is shifted right one place and the exponent is incremented.
- R8: When bits 16 and 15 of the sum are both clear and the sum is nonzero, the sum is shifted left one place per cycle and the exponent is decremented each time, until bit 15 is 1. A sum of zero is stored as the all-zero word.
- R9: A carry-out while the exponent is 255 raises `ovf`, and the stored word is zero.
- R10: A left shift needed while the exponent is 0 raises `udf`, and the stored word is zero.
- R11: The result word `{exponent, mantissa}` is written to address src_a with `mem_we` high for exactly one cycle. `done` is high in that same cycle only.
- R12: A `start` that arrives while `busy` is high has no effect. This includes a start in the cycle where `done` is high. The running operation keeps its addresses, and no new operation begins.
- R13: `ovf` and `udf` hold their value after `done` and clear in the cycle after the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe; taken only when idle |
| src_a | input | ADDR_W | Address of operand A, which is also the destination |
| src_b | input | ADDR_W | Address of operand B |
| busy | output | 1 | High from the cycle after an accepted start through the store cycle |
| done | output | 1 | One-cycle pulse in the store cycle |
| ovf | output | 1 | Exponent overflow flag, held until the next start |
| udf | output | 1 | Exponent underflow flag, held until the next start |
| mem_addr | output | ADDR_W | Store address for both reads and the write |
| mem_rdata | input | EXP_W+MAN_W | Combinational read data from the store |
| mem_we | output | 1 | Store write enable |
| mem_wdata | output | EXP_W+MAN_W | Result word written to the store |

## Verification
The carry right shift and the overflow check both act in the same normalise step whenever the running exponent is 255. The sweep reaches this case by adding operands with exponent 255 whose mantissa sum carries. The result must then be a zeroed word with `ovf` set, never an exponent that wraps to 0.

A second collision is a new `start` that arrives in the very cycle of `done` and the store. The bench provokes it on purpose. It judges the outcome by checking that `busy` is low in the following cycle and that the store holds no trace of the intruding addresses.

// File: rtl/fpaddms_pkg.sv
package fpaddms_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LD_E1,
        S_LD_M1,
        S_LD_E2,
        S_LD_M2,
        S_CMP,
        S_ALIGN,
        S_ADD,
        S_NORM,
        S_STORE
    } seq_t;

    typedef enum logic [1:0] {
        BR_EQ,
        BR_A_LT,
        BR_B_LT
    } br_t;

    typedef enum logic [2:0] {
        NS_RIGHT,
        NS_KEEP,
        NS_ZERO,
        NS_OVF,
        NS_UDF,
        NS_LEFT
    } norm_t;

endpackage

// File: rtl/fpaddms_cmp.sv
module fpaddms_cmp
    import fpaddms_pkg::*;
#(
    parameter int EXP_W = 8
) (
    input  logic [EXP_W-1:0] e1,
    input  logic [EXP_W-1:0] e2,
    output br_t              br,
    output logic [EXP_W-1:0] diff
);

    always_comb begin
        if (e1 == e2) begin
            br   = BR_EQ;
            diff = '0;
        end else if (e1 < e2) begin
            br   = BR_A_LT;
            diff = e2 - e1;
        end else begin
            br   = BR_B_LT;
            diff = e1 - e2;
        end
    end

endmodule

// File: rtl/fpaddms_rshift.sv
module fpaddms_rshift #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic [MAN_W-1:0] din,
    input  logic [EXP_W-1:0] amt,
    output logic [MAN_W-1:0] dout
);

    // Any shift of the full mantissa width or more empties the operand.
    always_comb begin
        if (int'(amt) >= MAN_W) begin
            dout = '0;
        end else begin
            dout = din >> amt;
        end
    end

endmodule

// File: rtl/fpaddms_norm.sv
module fpaddms_norm
    import fpaddms_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic [MAN_W:0]   mo,
    input  logic [EXP_W-1:0] eo,
    output norm_t            act,
    output logic [MAN_W:0]   mo_n,
    output logic [EXP_W-1:0] eo_n
);

    always_comb begin
        mo_n = mo;
        eo_n = eo;
        if (mo[MAN_W]) begin
            if (eo == {EXP_W{1'b1}}) begin
                act = NS_OVF;
            end else begin
                act  = NS_RIGHT;
                mo_n = mo >> 1;
                eo_n = eo + 1'b1;
            end
        end else if (mo[MAN_W-1]) begin
            act = NS_KEEP;
        end else if (mo == '0) begin
            act = NS_ZERO;
        end else if (eo == '0) begin
            act = NS_UDF;
        end else begin
            act  = NS_LEFT;
            mo_n = mo << 1;
            eo_n = eo - 1'b1;
        end
    end

endmodule

// File: rtl/fpaddms_top.sv
module fpaddms_top
    import fpaddms_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int MAN_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ADDR_W-1:0]      src_a,
    input  logic [ADDR_W-1:0]      src_b,
    output logic                   busy,
    output logic                   done,
    output logic                   ovf,
    output logic                   udf,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic [EXP_W+MAN_W-1:0] mem_rdata,
    output logic                   mem_we,
    output logic [EXP_W+MAN_W-1:0] mem_wdata
);

    localparam int WORD_W = EXP_W + MAN_W;

    typedef struct packed {
        seq_t              st;
        logic [ADDR_W-1:0] a_addr;
        logic [ADDR_W-1:0] b_addr;
        logic [EXP_W-1:0]  e1;
        logic [EXP_W-1:0]  e2;
        logic [EXP_W-1:0]  eo;
        logic [MAN_W-1:0]  m1;
        logic [MAN_W-1:0]  m2;
        logic [MAN_W:0]    mo;
        br_t               br;
        logic [EXP_W-1:0]  diff;
        logic              ovf;
        logic              udf;
    } regs_t;

    regs_t r_d, r_q;

    br_t              cmp_br;
    logic [EXP_W-1:0] cmp_diff;
    logic [MAN_W-1:0] sh_in, sh_out;
    logic [MAN_W:0]   sum;
    norm_t            n_act;
    logic [MAN_W:0]   n_mo;
    logic [EXP_W-1:0] n_eo;

    fpaddms_cmp #(.EXP_W(EXP_W)) u_cmp (
        .e1   (r_q.e1),
        .e2   (r_q.e2),
        .br   (cmp_br),
        .diff (cmp_diff)
    );

    assign sh_in = (r_q.br == BR_B_LT) ? r_q.m2 : r_q.m1;

    fpaddms_rshift #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rsh (
        .din  (sh_in),
        .amt  (r_q.diff),
        .dout (sh_out)
    );

    assign sum = {1'b0, r_q.m1} + {1'b0, r_q.m2};

    fpaddms_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .mo   (r_q.mo),
        .eo   (r_q.eo),
        .act  (n_act),
        .mo_n (n_mo),
        .eo_n (n_eo)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.a_addr = src_a;
                    r_d.b_addr = src_b;
                    r_d.ovf    = 1'b0;
                    r_d.udf    = 1'b0;
                    r_d.st     = S_LD_E1;
                end
            end
            S_LD_E1: begin
                r_d.e1 = mem_rdata[WORD_W-1:MAN_W];
                r_d.st = S_LD_M1;
            end
            S_LD_M1: begin
                r_d.m1 = mem_rdata[MAN_W-1:0];
                r_d.st = S_LD_E2;
            end
            S_LD_E2: begin
                r_d.e2 = mem_rdata[WORD_W-1:MAN_W];
                r_d.st = S_LD_M2;
            end
            S_LD_M2: begin
                r_d.m2 = mem_rdata[MAN_W-1:0];
                r_d.st = S_CMP;
            end
            S_CMP: begin
                r_d.br   = cmp_br;
                r_d.diff = cmp_diff;
                r_d.st   = S_ALIGN;
            end
            S_ALIGN: begin
                unique case (r_q.br)
                    BR_A_LT: begin
                        r_d.m1 = sh_out;
                        r_d.eo = r_q.e2;
                    end
                    BR_B_LT: begin
                        r_d.m2 = sh_out;
                        r_d.eo = r_q.e1;
                    end
                    default: begin
                        r_d.eo = r_q.e1;
                    end
                endcase
                r_d.st = S_ADD;
            end
            S_ADD: begin
                r_d.mo = sum;
                r_d.st = S_NORM;
            end
            S_NORM: begin
                unique case (n_act)
                    NS_RIGHT: begin
                        r_d.mo = n_mo;
                        r_d.eo = n_eo;
                        r_d.st = S_STORE;
                    end
                    NS_KEEP: begin
                        r_d.st = S_STORE;
                    end
                    NS_ZERO: begin
                        r_d.mo = '0;
                        r_d.eo = '0;
                        r_d.st = S_STORE;
                    end
                    NS_OVF: begin
                        r_d.ovf = 1'b1;
                        r_d.mo  = '0;
                        r_d.eo  = '0;
                        r_d.st  = S_STORE;
                    end
                    NS_UDF: begin
                        r_d.udf = 1'b1;
                        r_d.mo  = '0;
                        r_d.eo  = '0;
                        r_d.st  = S_STORE;
                    end
                    default: begin
                        r_d.mo = n_mo;
                        r_d.eo = n_eo;
                    end
                endcase
            end
            S_STORE: begin
                r_d.st = S_IDLE;
            end
            default: begin
                r_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, br: BR_EQ, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != S_IDLE);
    assign done      = (r_q.st == S_STORE);
    assign mem_we    = (r_q.st == S_STORE);
    assign mem_wdata = {r_q.eo, r_q.mo[MAN_W-1:0]};
    assign mem_addr  = (r_q.st == S_LD_E2 || r_q.st == S_LD_M2) ? r_q.b_addr : r_q.a_addr;
    assign ovf       = r_q.ovf;
    assign udf       = r_q.udf;

endmodule

// File: rtl/fpaddms_chk.sv
module fpaddms_chk #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              ovf,
    input logic              udf
);

    // R11
    done_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_we);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (mem_wdata == '0));

    // R10
    udf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && udf) |-> (mem_wdata == '0));

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && udf));

    // R13
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!ovf && !udf));

    // R13
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && busy) |=> ovf);

    // R12
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy);

endmodule

bind fpaddms_top fpaddms_chk #(.WORD_W(EXP_W + MAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .ovf       (ovf),
    .udf       (udf)
);

// File: tb/fpaddms_top_test.sv
`timescale 1ns/1ps
module fpaddms_top_test;

    localparam int EW = 8;
    localparam int MW = 16;
    localparam int AW = 3;
    localparam int WW = EW + MW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_a = '0;
    logic [AW-1:0] src_b = '0;
    logic          busy, done, ovf, udf, mem_we;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_rdata, mem_wdata;
    logic [WW-1:0] mem [8];

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fpaddms_top #(.EXP_W(EW), .MAN_W(MW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
        .busy(busy), .done(done), .ovf(ovf), .udf(udf),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            finished = 1;
            nfail++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic model of the requirements.
    task automatic model(input logic [WW-1:0] wa, input logic [WW-1:0] wb,
                         output logic [WW-1:0] res, output bit eo_v, output bit eu_v,
                         output string tag);
        int ea, eb, eo, d;
        int ma, mb, s;
        ea = int'(wa[WW-1:MW]); ma = int'(wa[MW-1:0]);
        eb = int'(wb[WW-1:MW]); mb = int'(wb[MW-1:0]);
        eo_v = 0; eu_v = 0;
        if (ea == eb) begin
            s = ma + mb; eo = ea; tag = "R3";
        end else if (ea < eb) begin
            d = eb - ea; tag = (d >= 16) ? "R6" : "R4";
            s = ((d >= 16) ? 0 : (ma >> d)) + mb; eo = eb;
        end else begin
            d = ea - eb; tag = (d >= 16) ? "R6" : "R5";
            s = ((d >= 16) ? 0 : (mb >> d)) + ma; eo = ea;
        end
        res = '0;
        if (s >= 65536) begin
            if (eo == 255) begin
                eo_v = 1; tag = "R9";
            end else begin
                tag = "R7";
                res = {8'(eo + 1), 16'(s >> 1)};
            end
        end else if (s == 0) begin
            res = '0;
        end else begin
            while (s < 32768 && !eu_v) begin
                tag = "R8";
                if (eo == 0) begin
                    eu_v = 1; tag = "R10";
                end else begin
                    s = s << 1; eo = eo - 1;
                end
            end
            if (!eu_v) res = {8'(eo), 16'(s)};
        end
    endtask

    task automatic run_op(input logic [AW-1:0] a, input logic [AW-1:0] b, input bit meddle);
        logic [WW-1:0] exp_w, keep5;
        bit eo_v, eu_v;
        string tag;
        int n;
        model(mem[a], mem[b], exp_w, eo_v, eu_v, tag);
        keep5 = mem[5];
        @(negedge clk);
        start = 1'b1; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy", 32'(busy), 1);
        chk(!ovf && !udf, "R13 clear", {30'd0, ovf, udf}, 0);
        chk(mem_addr == a, "R2 addr1", 32'(mem_addr), 32'(a));
        @(negedge clk);
        chk(mem_addr == a, "R2 addr2", 32'(mem_addr), 32'(a));
        if (meddle) begin
            start = 1'b1; src_a = 3'd5; src_b = 3'd6;
        end
        @(negedge clk);
        start = 1'b0; src_a = a; src_b = b;
        chk(mem_addr == b, "R2 addr3", 32'(mem_addr), 32'(b));
        @(negedge clk);
        chk(mem_addr == b, "R2 addr4", 32'(mem_addr), 32'(b));
        n = 0;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R11 done", 32'(done), 1);
        chk(mem_we && mem_addr == a, "R11 store", {mem_we, 28'd0, mem_addr}, {1'b1, 28'd0, a});
        chk(mem_wdata == exp_w, tag, 32'(mem_wdata), 32'(exp_w));
        chk(ovf == eo_v, "R9 ovf", 32'(ovf), 32'(eo_v));
        chk(udf == eu_v, "R10 udf", 32'(udf), 32'(eu_v));
        if (meddle) begin
            start = 1'b1; src_a = 3'd5; src_b = 3'd6;
        end
        @(negedge clk);
        start = 1'b0;
        chk(!done && !mem_we, "R11 pulse", {done, mem_we}, 0);
        if (meddle) begin
            chk(busy == 1'b0, "R12 done-cycle start", 32'(busy), 0);
            chk(mem[5] == keep5, "R12 no stray store", 32'(mem[5]), 32'(keep5));
            chk(mem[a] == exp_w, "R12 kept addresses", 32'(mem[a]), 32'(exp_w));
        end
        chk(ovf == eo_v && udf == eu_v, "R13 hold", {ovf, udf}, {eo_v, eu_v});
    endtask

    initial begin
        logic [7:0]  exps [9];
        logic [15:0] mans [6];
        exps = '{8'd0, 8'd1, 8'd2, 8'd15, 8'd16, 8'd17, 8'd128, 8'd254, 8'd255};
        mans = '{16'h0000, 16'h0001, 16'h0300, 16'h8000, 16'hC001, 16'hFFFF};
        for (int i = 0; i < 8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_we && !ovf && !udf, "R1 reset",
            {busy, done, mem_we, ovf, udf}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !ovf && !udf, "R1 idle",
            {busy, done, mem_we, ovf, udf}, 0);

        // R12: start during the run and in the store cycle is ignored.
        mem[0] = {8'd20, 16'h9000}; mem[1] = {8'd18, 16'hA000};
        mem[5] = 24'h123456; mem[6] = 24'h654321;
        run_op(3'd0, 3'd1, 1'b1);

        // R9 then R13: overflow flag held, then cleared by the next start.
        mem[2] = {8'd255, 16'hFFFF}; mem[3] = {8'd255, 16'hFFFF};
        run_op(3'd2, 3'd3, 1'b0);
        repeat (3) @(negedge clk);
        chk(ovf == 1'b1, "R13 ovf held idle", 32'(ovf), 1);
        mem[2] = {8'd10, 16'h8000}; mem[3] = {8'd10, 16'h8000};
        run_op(3'd2, 3'd3, 1'b0);

        // Near-exhaustive sweep over exponent and mantissa corner values.
        for (int ia = 0; ia < 9; ia++)
            for (int ib = 0; ib < 9; ib++)
                for (int ja = 0; ja < 6; ja++)
                    for (int jb = 0; jb < 6; jb++) begin
                        mem[4] = {exps[ia], mans[ja]};
                        mem[7] = {exps[ib], mans[jb]};
                        run_op(3'd4, 3'd7, 1'b0);
                    end

        // Same address for both operands: doubling.
        mem[1] = {8'd40, 16'hC000};
        run_op(3'd1, 3'd1, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule